// File: doc/BRIEF.md
# Edge-Selective Pin Change Detector

This block watches an 8-bit input port and reports level changes per pin. Rising and falling edges are armed independently for each pin through two enable registers. A direction register marks which pins are inputs, and only inputs can report. Each reported edge latches a bit in a per-pin flag register. It also raises a shared change flag and emits a one-cycle wake request, so a sleeping core can be woken.

Software reaches the four registers through a small write port with a combinational read mux. It clears flag bits by writing zeros to them. Pin levels arrive already synchronized to the clock. An enable input gates both edge reporting and the shared flag output.

Top module: `ioc_unit`

## Requirements
- R1: A rising edge on pin n (previous level 0, new level 1) is reported only when bit n of the rising-enable register is 1 and bit n of the direction register is 1 (1 = input).
- R2: A falling edge on pin n (previous level 1, new level 0) is reported only when bit n of the falling-enable register is 1 and the pin is an input.
- R3: A reported edge on pin n sets flag bit n on the clock edge that samples the new level. Other flag bits keep their values.
- R4: A reported edge makes `wake` high for exactly the one cycle after the sampling clock edge. The shared flag rises in that same cycle.
- R5: Edges are found by comparing each pin's sampled level with the level that pin had on the previous clock edge. A pin held steady reports nothing.
- R6: All pins are evaluated together, so several flag bits may set on the same clock edge.
- R7: A register write to the flag register clears each flag bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. A hardware set on the same edge overrides the clear.
- R8: While `unit_en` is 1, `chg_flag` equals the OR of all flag bits. While `unit_en` is 0, `chg_flag` is 0, no edge is reported, and flag bits are kept.
- R9: Register addresses are 0 = rising enable, 1 = falling enable, 2 = flags, 3 = direction. `rdata` shows the addressed register combinationally. After reset, both enable registers and the flags are 0 and direction is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Enables edge reporting and the shared flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Addressed register contents |
| pins_in | input | 8 | Synchronized pin levels |
| chg_flag | output | 1 | Shared change-interrupt flag |
| wake | output | 1 | One-cycle wake request |

## Verification
The assertions assume that `pins_in` is already synchronous to `clk` and stable at every rising edge. They also assume that the pins are low during reset, because the previous-level history resets to zero. The stimulus changes pins and register inputs only on falling edges and holds the pins low through reset. Under those conditions every new flag bit can be traced to one armed edge on an input pin, and a flag bit can only drop through a write to address 2.

// File: rtl/ioc_unit.sv
module ioc_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unit_en,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pins_in,
  output logic         chg_flag,
  output logic         wake
);

  logic [W-1:0] pos_q, neg_q, flag_q, dir_q, prev_q;
  logic [W-1:0] rise, fall, hits, flag_kept;

  assign rise = pins_in & ~prev_q & pos_q;
  assign fall = ~pins_in & prev_q & neg_q;
  assign hits = unit_en ? (dir_q & (rise | fall)) : '0;
  assign flag_kept = (wr_en && addr == 2'd2) ? (flag_q & wdata) : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      neg_q  <= '0;
      flag_q <= '0;
      dir_q  <= '1;
      prev_q <= '0;
      wake   <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd0) pos_q <= wdata;
      if (wr_en && addr == 2'd1) neg_q <= wdata;
      if (wr_en && addr == 2'd3) dir_q <= wdata;
      flag_q <= flag_kept | hits;
      prev_q <= pins_in;
      wake   <= |hits;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = pos_q;
      2'd1:    rdata = neg_q;
      2'd2:    rdata = flag_q;
      default: rdata = dir_q;
    endcase
  end

  assign chg_flag = unit_en & (|flag_q);

endmodule

// File: rtl/ioc_unit_chk.sv
module ioc_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         unit_en,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] pins_in,
  input logic [W-1:0] prev_q,
  input logic [W-1:0] pos_q,
  input logic [W-1:0] neg_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] flag_q,
  input logic         wake
);

  a_r1_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & $past(pins_in) & ~$past(prev_q)
      & ~($past(pos_q) & $past(dir_q))) == '0));

  a_r2_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(pins_in) & $past(prev_q)
      & ~($past(neg_q) & $past(dir_q))) == '0));

  a_r5_new_flag_from_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~($past(pins_in) ^ $past(prev_q))) == '0));

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(wr_en) && $past(addr) == 2'd2) |-> (($past(flag_q) & ~flag_q) == '0));

  a_r4_wake_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (flag_q != '0));

  a_r8_disabled_no_report: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unit_en) |-> ((flag_q & ~$past(flag_q)) == '0 && !wake));

endmodule

bind ioc_unit ioc_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .wr_en(wr_en), .addr(addr),
  .pins_in(pins_in), .prev_q(prev_q), .pos_q(pos_q), .neg_q(neg_q),
  .dir_q(dir_q), .flag_q(flag_q), .wake(wake)
);

// File: tb/ioc_unit_bench.sv
module ioc_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       unit_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pins_in = 8'h00;
  logic       chg_flag, wake;

  ioc_unit u_ioc_unit (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .chg_flag(chg_flag), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         req;
    logic [7:0] rd;
    logic       wk;
    logic       cf;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_pos, m_neg, m_flag, m_dir, m_prev;

  task automatic check(int req, logic [7:0] rd, logic wk, logic cf,
                       logic [7:0] erd, logic ewk, logic ecf);
    total++;
    if (rd !== erd || wk !== ewk || cf !== ecf) begin
      bad++;
      $display("FAIL R%0d: rdata=%h wake=%b chg=%b expected rdata=%h wake=%b chg=%b",
               req, rd, wk, cf, erd, ewk, ecf);
    end
  endtask

  task automatic step(int req, logic en, logic wr, logic [1:0] a,
                      logic [7:0] wd, logic [7:0] pins);
    logic [7:0] hits;
    exp_t e;
    @(negedge clk);
    unit_en = en; wr_en = wr; addr = a; wdata = wd; pins_in = pins;
    hits = en ? (m_dir & ((pins & ~m_prev & m_pos) | (~pins & m_prev & m_neg))) : 8'h00;
    if (wr) begin
      case (a)
        2'd0: m_pos = wd;
        2'd1: m_neg = wd;
        2'd2: m_flag = m_flag & wd;
        default: m_dir = wd;
      endcase
    end
    m_flag = m_flag | hits;
    m_prev = pins;
    e.req = req;
    e.wk = |hits;
    e.cf = en & (|m_flag);
    case (a)
      2'd0: e.rd = m_pos;
      2'd1: e.rd = m_neg;
      2'd2: e.rd = m_flag;
      default: e.rd = m_dir;
    endcase
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, rdata, wake, chg_flag, e.rd, e.wk, e.cf);
      end
    end
  end

  initial begin
    m_pos = 8'h00; m_neg = 8'h00; m_flag = 8'h00; m_dir = 8'hFF; m_prev = 8'h00;
    repeat (3) @(negedge clk);
    addr = 2'd3;
    #1;
    check(9, rdata, wake, chg_flag, 8'hFF, 1'b0, 1'b0);   // R9 direction reset
    addr = 2'd2;
    #1;
    check(9, rdata, wake, chg_flag, 8'h00, 1'b0, 1'b0);   // R9 flags reset
    rst_n = 1'b1;

    step(9, 1, 1, 2'd0, 8'h0F, 8'h00);   // R9 rising enable low nibble
    step(9, 1, 1, 2'd1, 8'hF0, 8'h00);   // R9 falling enable high nibble
    step(3, 1, 0, 2'd2, 8'h00, 8'h01);   // R3 R4 armed rise bit0
    step(5, 1, 0, 2'd2, 8'h00, 8'h01);   // R5 steady level
    step(1, 1, 0, 2'd2, 8'h00, 8'h11);   // R1 rise bit4 not armed
    step(2, 1, 0, 2'd2, 8'h00, 8'h01);   // R2 fall bit4 armed
    step(2, 1, 0, 2'd2, 8'h00, 8'h00);   // R2 fall bit0 not armed
    step(9, 1, 1, 2'd3, 8'hFE, 8'h00);   // R9 bit0 becomes output
    step(1, 1, 0, 2'd2, 8'h00, 8'h01);   // R1 rise on output pin ignored
    step(7, 1, 1, 2'd2, 8'h00, 8'h01);   // R7 clear all flags
    step(6, 1, 0, 2'd2, 8'h00, 8'h0E);   // R6 three rises together
    step(7, 1, 1, 2'd2, 8'hF7, 8'h0E);   // R7 clear bit3 only
    step(5, 1, 0, 2'd2, 8'h00, 8'h00);   // R5 unarmed falls
    step(7, 1, 1, 2'd2, 8'h00, 8'h02);   // R7 set beats clear
    step(8, 0, 0, 2'd2, 8'h00, 8'h00);   // R8 disabled, shared flag low
    step(8, 0, 0, 2'd2, 8'h00, 8'h04);   // R8 armed rise ignored while disabled
    step(8, 1, 0, 2'd2, 8'h00, 8'h04);   // R8 re-enabled, shared flag back
    step(9, 1, 1, 2'd3, 8'hFF, 8'h04);   // R9 all inputs
    step(1, 1, 0, 2'd2, 8'h00, 8'hF4);   // R1 high nibble rises not armed
    step(6, 1, 0, 2'd2, 8'h00, 8'h04);   // R6 R2 four falls together
    step(7, 1, 1, 2'd2, 8'h00, 8'h04);   // R7 clear, shared flag drops
    step(9, 1, 0, 2'd0, 8'h00, 8'h04);   // R9 read rising enable
    step(9, 1, 0, 2'd1, 8'h00, 8'h04);   // R9 read falling enable

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule